// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of `W` bits (32 by default) and returns the full `2W`-bit signed product. It uses radix-2 Booth recoding and performs one recoding step per clock.

A caller raises `start` for one cycle while the block is idle. On that edge the block captures the multiplicand and the multiplier. It then holds `busy` high for exactly `W` cycles. Next it pulses `done` for one cycle, and from that cycle `product` holds the result.

All work happens in one combined shift register. The upper half is the running partial product. The lower half starts as the multiplier. A single guard bit sits to the right of the lower half and starts at zero. On each step the lowest multiplier bit and the guard bit form a pair, and that pair selects one of three actions on the upper half: add the multiplicand, subtract it, or leave it alone. The whole register then shifts right by one place and keeps its sign. The adder is one bit wider than the operands, so an intermediate sign is never lost. This keeps the most negative operand correct.

Top module: `booth_seq_mul`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: When `start` is 1 on a clock edge while `busy` is 0, the block captures both operands on that edge, and `busy` reads 1 in the following cycle.
- R3: `busy` stays high for exactly `W` cycles after an accepted start. `done` is 1 in the cycle right after the last busy cycle.
- R4: `done` is high for a single cycle, and `busy` is 0 whenever `done` is 1.
- R5: `start` is ignored while `busy` is 1. Operands presented then do not affect the result, and the busy length does not change.
- R6: Each step forms the pair (lowest multiplier bit, guard bit). The pair (1,0) subtracts the multiplicand from the upper half, the pair (0,1) adds it, and the pairs (0,0) and (1,1) leave the upper half unchanged. The register then shifts right arithmetically. The guard bit is 0 at the first step.
- R7: When `done` is 1, `product` equals the signed product of the captured operands for every operand pair. This includes 0, -1, the most positive value and the most negative value; for example, (-2^(W-1)) × (-2^(W-1)) gives 2^(2W-2).
- R8: While `busy` is 0 and no start is accepted, `product` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiply; honoured only when idle |
| multiplicand | input | W | Signed multiplicand |
| multiplier | input | W | Signed multiplier |
| busy | output | 1 | High while recoding steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2W | Signed product, valid from `done` until the next accepted start |

## Verification
The result is due a fixed `W + 1` cycles after the edge that accepts `start`. `busy` is due one cycle after that edge, and `done` falls one cycle after it rises. The bench drives on falling edges and samples on falling edges. It counts the busy cycles one at a time and checks `done` and `product` at the first falling edge where `busy` has dropped. It then checks one cycle later that `done` has cleared and that the product has held. For a start issued in the middle of a run, the bench checks the next result against the first operands.

// File: rtl/booth_pkg.sv
// Package: shared types for the sequential Booth multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package booth_pkg;

    // Action selected by one radix-2 recoding step
    typedef enum logic [1:0] {
        BOOTH_SKIP = 2'd0,
        BOOTH_ADD  = 2'd1,
        BOOTH_SUB  = 2'd2
    } booth_op_e;

    // Controller states
    typedef enum logic {
        CTRL_IDLE = 1'b0,
        CTRL_RUN  = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/booth_recoder.sv
// Module: booth_recoder
// Maps the pair (current multiplier bit, guard bit) to an action:
// (1,0) subtract, (0,1) add, equal bits skip.
// Assumes: purely combinational, evaluated once per step.
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      guard_bit,
    output booth_op_e op
);

    // Decode the bit pair into the accumulator action
    always_comb begin
        unique case ({cur_bit, guard_bit})
            2'b10:   op = BOOTH_SUB;
            2'b01:   op = BOOTH_ADD;
            default: op = BOOTH_SKIP;
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
// Module: booth_addsub
// Adds, subtracts or passes the multiplicand against the accumulator.
// The operation runs on W+1 bits so that the sign survives into the shift.
// Assumes: both inputs are signed W-bit values; the result is sign-exact.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mcand,
    input  booth_op_e    op,
    output logic [W:0]   sum
);

    localparam int XW = W + 1;

    logic [XW-1:0] acc_x;
    logic [XW-1:0] mcand_x;
    logic [XW-1:0] operand;
    logic          carry_in;

    // Sign-extend both inputs by one bit
    always_comb begin
        acc_x   = {acc[W-1], acc};
        mcand_x = {mcand[W-1], mcand};
    end

    // Select the second operand: zero, the multiplicand, or its ones' complement
    genvar gi;
    generate
        for (gi = 0; gi < XW; gi++) begin : g_opsel
            always_comb begin
                unique case (op)
                    BOOTH_ADD: operand[gi] = mcand_x[gi];
                    BOOTH_SUB: operand[gi] = ~mcand_x[gi];
                    default:   operand[gi] = 1'b0;
                endcase
            end
        end
    endgenerate

    // Carry-in completes the two's complement for subtraction
    always_comb carry_in = (op == BOOTH_SUB);

    // Single wide adder
    always_comb sum = acc_x + operand + {{(XW-1){1'b0}}, carry_in};

endmodule

// File: rtl/booth_ctrl.sv
// Module: booth_ctrl
// Step sequencer: accepts start when idle, issues W step strobes,
// then pulses done for one cycle.
// Assumes: synchronous active-low reset; start is ignored while running.
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    ctrl_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Strobes derived from the current state
    always_comb begin
        load = (state_q == CTRL_IDLE) && start;
        step = (state_q == CTRL_RUN);
        busy = (state_q == CTRL_RUN);
        done = done_q;
    end

    // State, step counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTRL_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                CTRL_IDLE: begin
                    if (start) begin
                        state_q <= CTRL_RUN;
                        cnt_q   <= '0;
                    end
                end
                CTRL_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= CTRL_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= CTRL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/booth_seq_mul.sv
// Module: booth_seq_mul (top)
// Sequential radix-2 Booth multiplier. The combined register is
// {acc, mplr, guard}: acc collects the partial product, mplr holds the
// multiplier, and guard is the bit shifted out on the right. Each step
// recodes {mplr[0], guard}, updates acc through a W+1-bit adder and shifts
// everything right arithmetically.
// Assumes: operands are signed two's complement; W >= 2.
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     multiplicand,
    input  logic [W-1:0]     multiplier,
    output logic             busy,
    output logic             done,
    output logic [2*W-1:0]   product
);

    logic [W-1:0] acc_q;
    logic [W-1:0] mplr_q;
    logic         guard_q;
    logic [W-1:0] mcand_q;

    logic         load;
    logic         step;
    booth_op_e    op;
    logic [W:0]   sum;

    // Sequencer
    booth_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    // Recoding of the current bit pair
    booth_recoder u_recoder (
        .cur_bit   (mplr_q[0]),
        .guard_bit (guard_q),
        .op        (op)
    );

    // Partial-product adder
    booth_addsub #(.W(W)) u_addsub (
        .acc   (acc_q),
        .mcand (mcand_q),
        .op    (op),
        .sum   (sum)
    );

    // Combined register: load on start, add/sub then arithmetic shift per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mplr_q  <= '0;
            guard_q <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc_q   <= '0;
            mplr_q  <= multiplier;
            guard_q <= 1'b0;
            mcand_q <= multiplicand;
        end else if (step) begin
            acc_q   <= sum[W:1];
            mplr_q  <= {sum[0], mplr_q[W-1:1]};
            guard_q <= mplr_q[0];
        end
    end

    // Product is the upper and lower halves side by side
    always_comb product = {acc_q, mplr_q};

endmodule

// File: rtl/booth_seq_mul_chk.sv
// Module: booth_seq_mul_chk
// Protocol checker bound to booth_seq_mul; observes ports only.
// Assumes: same W as the checked instance.
module booth_seq_mul_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);

    int   run_cnt;
    logic rst_seen_q = 1'b0;

    // Count busy cycles since the last accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)               run_cnt <= 0;
        else if (start && !busy)  run_cnt <= 0;
        else if (busy)            run_cnt <= run_cnt + 1;
    end

    // Remember whether the previous edge was in reset
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1: outputs are cleared after a reset edge
    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_idle_R1: assert (!busy && !done && product == '0)
                else $error("R1 reset state wrong");
        end
    end

    // R2: accepted start makes busy high next cycle
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3: busy lasts exactly W cycles and done follows
    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == W));
    assert_done_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4: done is a single-cycle pulse outside busy
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: product holds while idle with no start
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_seq_mul_bench.sv
module booth_seq_mul_bench;

    localparam int W  = 32;
    localparam int WS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic            start = 1'b0;
    logic [W-1:0]    mcand = '0;
    logic [W-1:0]    mplr  = '0;
    logic            busy, done;
    logic [2*W-1:0]  product;

    logic            s_start = 1'b0;
    logic [WS-1:0]   s_mcand = '0;
    logic [WS-1:0]   s_mplr  = '0;
    logic            s_busy, s_done;
    logic [2*WS-1:0] s_product;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    booth_seq_mul #(.W(W)) u_booth_seq_mul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .multiplicand(mcand), .multiplier(mplr),
        .busy(busy), .done(done), .product(product)
    );

    booth_seq_mul #(.W(WS)) u_booth_seq_mul_small (
        .clk(clk), .rst_n(rst_n), .start(s_start),
        .multiplicand(s_mcand), .multiplier(s_mplr),
        .busy(s_busy), .done(s_done), .product(s_product)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            summary();
        end
    end

    // Full-width multiply with timing checks; optional start pulse mid-run (R5)
    task automatic run_wide(input logic [W-1:0] a, input logic [W-1:0] b,
                            input bit poke);
        longint exp;
        int nb;
        logic [2*W-1:0] held;
        exp = longint'($signed(a)) * longint'($signed(b));
        @(negedge clk);
        mcand = a; mplr = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
        nb = 0;
        while (busy && nb < W + 4) begin
            nb++;
            if (poke && nb == 3) begin
                mcand = ~a; mplr = b + 32'd7; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
        end
        check(nb == W, "R3", "busy cycle count", longint'(nb), longint'(W));
        check(done == 1'b1, "R3", "done after last step", longint'(done), 1);
        check($signed(product) == exp, poke ? "R5" : "R7", "product",
              longint'($signed(product)), exp);
        held = product;
        @(negedge clk);
        check(done == 1'b0, "R4", "done one cycle", longint'(done), 0);
        check(busy == 1'b0, "R5", "no restart from ignored start",
              longint'(busy), 0);
        @(negedge clk);
        check(product == held, "R8", "product holds", longint'($signed(product)),
              longint'($signed(held)));
    endtask

    // Small-width multiply: result only (R6, R7)
    task automatic run_small(input logic [WS-1:0] a, input logic [WS-1:0] b);
        int exp;
        int guard;
        exp = int'($signed(a)) * int'($signed(b));
        @(negedge clk);
        s_mcand = a; s_mplr = b; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        guard = 0;
        while (!s_done && guard < WS + 4) begin
            guard++;
            @(negedge clk);
        end
        check(s_done && int'($signed(s_product)) == exp, "R6",
              "small product", longint'($signed(s_product)), longint'(exp));
    endtask

    initial begin
        logic [W-1:0] corner [5];
        logic [W-1:0] ra, rb;
        corner[0] = 32'h0000_0000;
        corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h8000_0000;
        corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h0000_0001;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy in reset", longint'(busy), 0);
        check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
        check(product == '0, "R1", "product in reset", longint'(product), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && product == '0, "R1", "idle after reset",
              longint'(busy), 0);

        // R7: most negative squared gives 2^62
        run_wide(32'h8000_0000, 32'h8000_0000, 0);
        check(product == 64'h4000_0000_0000_0000, "R7", "min*min",
              longint'(product), 64'h4000_0000_0000_0000);

        // R7: corner operand pairs
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                run_wide(corner[i], corner[j], 0);

        // R7: pseudo-random operands
        ra = 32'h1234_5678; rb = 32'h9ABC_DEF1;
        for (int k = 0; k < 60; k++) begin
            ra = ra * 32'd1664525 + 32'd1013904223;
            rb = rb ^ (rb << 13); rb = rb ^ (rb >> 17); rb = rb ^ (rb << 5);
            run_wide(ra, rb, 0);
        end

        // R5: start during busy is ignored
        run_wide(32'hFFFF_FFF3, 32'h0000_1234, 1);
        run_wide(32'h8000_0000, 32'h7FFF_FFFF, 1);

        // R6, R7: exhaustive sweep of the small configuration
        for (int a = 0; a < (1 << WS); a++)
            for (int b = 0; b < (1 << WS); b++)
                run_small(WS'(a), WS'(b));

        summary();
    end

endmodule